// File: doc/BRIEF.md
# I/O Port Control and Status Registers

This block is the software-visible register set behind one general-purpose I/O port of a small microcontroller. The bus side is a three-bit address with write and read strobes and a byte-wide data path. Software uses it to set the value each pin drives, the direction of each pin and the electrical mode of each pin. It also reads the live pin levels and the enables actually in force.

The block also holds a bank of output macrocell flip-flops for the neighbouring programmable logic. A mask register can protect any of these flip-flops from bus writes. A set of input macrocells takes a snapshot of the pins when an external strobe rises. Each pin is enabled either by its direction bit or by an enable term from the programmable logic. A pin in open-drain mode that holds a 1 is released rather than driven.

Top module: `gpio_port_regs`

## Requirements
- R1: After a synchronous active-low reset, every writable register, the macrocell bank, the input snapshot and the read data are all 0.
- R2: A read of offset 0 returns the current `pin_in` value. A write to offset 0 has no effect.
- R3: Offset 1 is the output data register. It reads back the last value written, and `pin_out` always equals it.
- R4: When no open-drain release applies, pin i has `pin_oe[i]` = direction bit i (offset 2) OR `pld_oe[i]`.
- R5: Bits 7..4 of the drive register (offset 3) select open-drain for pins 7..4. On such a pin, an output data bit of 1 forces `pin_oe` low, and an output data bit of 0 leaves the enable as R4 gives it.
- R6: The drive register reads back as written. Its bits 3..0 appear on `slew_sel`.
- R7: A write to offset 4 loads each macrocell flip-flop whose mask bit (offset 5) is 0. Flip-flops whose mask bit is 1 keep their value. The bank is on `mcell_out` and reads back at offset 4.
- R8: The mask register at offset 5 is readable and writable, and it resets to 0 (nothing blocked).
- R9: Offset 7 returns the effective `pin_oe` vector. A write to offset 7 has no effect.
- R10: Offset 6 returns the input snapshot. The snapshot takes `pin_in` on the clock where `imc_strobe` is first seen high and holds at all other times. A write to offset 6 has no effect.
- R11: Read data appears on `bus_rdata` one clock after the cycle in which `bus_rd` is high. It holds while no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Pin levels seen at the pads |
| pld_oe | input | 8 | Per-pin output enable term from the programmable logic |
| imc_strobe | input | 1 | Input snapshot strobe, acts on its rising edge |
| pin_out | output | 8 | Value to drive on each pin |
| pin_oe | output | 8 | Effective per-pin output enable |
| slew_sel | output | 4 | Slew-rate selects for pins 3..0 |
| mcell_out | output | 8 | Output macrocell flip-flops |

## Verification
The bench builds the block with the default width of 8. At this width the drive register splits into the open-drain half and the slew half that R5 and R6 describe, so the release of a driven 1 is tested on an upper pin and has no counterpart on a lower pin. With this width, one mask pattern covers blocked and unblocked macrocells in the same write. The same test also holds the snapshot strobe high while the pins change, which confirms that only the rising edge captures.

// File: rtl/gpio_port_pkg.sv
// Shared register offsets for the I/O port register file.
// Assumes a 3-bit offset space with eight locations.
package gpio_port_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        OFS_PINS  = 3'd0,
        OFS_DOUT  = 3'd1,
        OFS_DIR   = 3'd2,
        OFS_DRIVE = 3'd3,
        OFS_MCELL = 3'd4,
        OFS_MASK  = 3'd5,
        OFS_SNAP  = 3'd6,
        OFS_OEVW  = 3'd7
    } port_ofs_e;
endpackage

// File: rtl/gpio_reg_bank.sv
// Writable registers of the port: output data, direction, drive mode,
// macrocell mask and the masked macrocell flip-flops.
// Assumes a single-cycle write strobe. Every register resets synchronously to 0.
module gpio_reg_bank
    import gpio_port_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] dout_q,
    output logic [DATA_W-1:0] dir_q,
    output logic [DATA_W-1:0] drv_q,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] mcell_q
);
    // Register updates. Macrocells load only where the mask bit is 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q  <= '0;
            dir_q   <= '0;
            drv_q   <= '0;
            mask_q  <= '0;
            mcell_q <= '0;
        end else if (wr_en) begin
            unique case (port_ofs_e'(wr_addr))
                OFS_DOUT:  dout_q  <= wr_data;
                OFS_DIR:   dir_q   <= wr_data;
                OFS_DRIVE: drv_q   <= wr_data;
                OFS_MASK:  mask_q  <= wr_data;
                OFS_MCELL: mcell_q <= (mcell_q & mask_q) | (wr_data & ~mask_q);
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/gpio_snap_latch.sv
// Input macrocell snapshot. It captures the pin levels on the first clock
// where the strobe is seen high and holds them until the next rising edge.
// Assumes the strobe is already synchronous to clk.
module gpio_snap_latch #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [DATA_W-1:0] pins,
    output logic [DATA_W-1:0] snap_q,
    output logic              cap_pulse
);
    logic strobe_d;

    // Rising-edge detect on the strobe.
    assign cap_pulse = strobe & ~strobe_d;

    // Strobe history and snapshot storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_d <= 1'b0;
            snap_q   <= '0;
        end else begin
            strobe_d <= strobe;
            if (cap_pulse) snap_q <= pins;
        end
    end
endmodule

// File: rtl/gpio_pin_drive.sv
// Per-pin output stage. The enable is direction OR logic term. On the upper
// half of the pins, open-drain mode releases the pin when its data bit is 1.
// Assumes an even DATA_W: the upper half is open-drain capable.
module gpio_pin_drive #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] dout,
    input  logic [DATA_W-1:0] dir,
    input  logic [DATA_W-1:0] drv,
    input  logic [DATA_W-1:0] pld_oe,
    output logic [DATA_W-1:0] pin_out,
    output logic [DATA_W-1:0] pin_oe
);
    localparam int OD_LO = DATA_W / 2;

    assign pin_out = dout;

    for (genvar i = 0; i < DATA_W; i++) begin : g_pin
        if (i >= OD_LO) begin : g_od
            // Open-drain capable pin: a driven 1 becomes a release.
            assign pin_oe[i] = (dir[i] | pld_oe[i]) & ~(drv[i] & dout[i]);
        end else begin : g_pp
            // Push-pull pin: enable straight from direction or logic term.
            assign pin_oe[i] = dir[i] | pld_oe[i];
        end
    end
endmodule

// File: rtl/gpio_port_regs.sv
// Top of the I/O port register file. It decodes bus writes into the
// register bank and registers the read data one clock after bus_rd.
// Assumes the bus keeps the strobes to one cycle and that the open-drain
// selects sit in the upper half of the drive register.
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] pin_in,
    input  logic [DATA_W-1:0] pld_oe,
    input  logic              imc_strobe,
    output logic [DATA_W-1:0] pin_out,
    output logic [DATA_W-1:0] pin_oe,
    output logic [HALF_W-1:0] slew_sel,
    output logic [DATA_W-1:0] mcell_out
);
    logic [DATA_W-1:0] dout_q, dir_q, drv_q, mask_q, snap_q;
    logic              cap_pulse;
    logic [DATA_W-1:0] rd_mux;

    gpio_reg_bank #(.DATA_W(DATA_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .wr_addr (bus_addr),
        .wr_data (bus_wdata),
        .dout_q  (dout_q),
        .dir_q   (dir_q),
        .drv_q   (drv_q),
        .mask_q  (mask_q),
        .mcell_q (mcell_out)
    );

    gpio_snap_latch #(.DATA_W(DATA_W)) u_snap (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (imc_strobe),
        .pins      (pin_in),
        .snap_q    (snap_q),
        .cap_pulse (cap_pulse)
    );

    gpio_pin_drive #(.DATA_W(DATA_W)) u_drive (
        .dout    (dout_q),
        .dir     (dir_q),
        .drv     (drv_q),
        .pld_oe  (pld_oe),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    assign slew_sel = drv_q[HALF_W-1:0];

    // Select the location addressed by the bus.
    always_comb begin
        unique case (port_ofs_e'(bus_addr))
            OFS_PINS:  rd_mux = pin_in;
            OFS_DOUT:  rd_mux = dout_q;
            OFS_DIR:   rd_mux = dir_q;
            OFS_DRIVE: rd_mux = drv_q;
            OFS_MCELL: rd_mux = mcell_out;
            OFS_MASK:  rd_mux = mask_q;
            OFS_SNAP:  rd_mux = snap_q;
            OFS_OEVW:  rd_mux = pin_oe;
            default:   rd_mux = '0;
        endcase
    end

    // Read data register: loads on a read strobe and holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/gpio_port_regs_chk.sv
// Checker for gpio_port_regs. It watches bus traffic, the register state
// and the pin outputs, and is bound to every instance of the top.
module gpio_port_regs_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] pin_out,
    input logic [DATA_W-1:0] pin_oe,
    input logic [DATA_W-1:0] dir_q,
    input logic [DATA_W-1:0] drv_q,
    input logic [DATA_W-1:0] mask_q,
    input logic [DATA_W-1:0] mcell_out,
    input logic [DATA_W-1:0] snap_q,
    input logic              cap_pulse
);
    localparam int OD_LO = DATA_W / 2;

    // R3: a data-out write shows on the pins the next cycle.
    assert_dout_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd1) |=> (pin_out == $past(bus_wdata)));

    // R4: a set direction bit enables a pin unless an open-drain release applies.
    assert_dir_enables_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((dir_q & ~({drv_q[DATA_W-1:OD_LO], {OD_LO{1'b0}}} & pin_out) & ~pin_oe) == '0));

    // R5: an open-drain pin holding 1 is never driven.
    assert_od_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe[DATA_W-1:OD_LO] & drv_q[DATA_W-1:OD_LO] & pin_out[DATA_W-1:OD_LO]) == '0));

    // R7: masked macrocells keep their value across a macrocell write.
    assert_mask_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd4) |=> ((mcell_out & $past(mask_q)) == ($past(mcell_out) & $past(mask_q))));

    // R10: the snapshot holds unless a strobe rising edge was seen.
    assert_snap_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_pulse |=> $stable(snap_q));

    // R11: read data holds when no read is issued.
    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

bind gpio_port_regs gpio_port_regs_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .dir_q     (dir_q),
    .drv_q     (drv_q),
    .mask_q    (mask_q),
    .mcell_out (mcell_out),
    .snap_q    (snap_q),
    .cap_pulse (cap_pulse)
);

// File: tb/sim_gpio_port_regs.sv
// Scoreboard bench for gpio_port_regs. The driver tasks queue the read data
// they expect, and a monitor compares each queued value with bus_rdata.
module sim_gpio_port_regs;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   bus_addr = '0;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic [W-1:0] pin_in = '0;
    logic [W-1:0] pld_oe = '0;
    logic         imc_strobe = 1'b0;
    logic [W-1:0] pin_out, pin_oe, mcell_out;
    logic [3:0]   slew_sel;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [W-1:0] exp_q[$];
    string        tag_q[$];
    logic         rd_seen = 1'b0;

    always #2.5 clk = ~clk;

    gpio_port_regs u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pld_oe(pld_oe), .imc_strobe(imc_strobe),
        .pin_out(pin_out), .pin_oe(pin_oe), .slew_sel(slew_sel),
        .mcell_out(mcell_out)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [W-1:0] exp, input string tag);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Monitor: note which cycles carried a read strobe.
    always @(posedge clk) rd_seen <= bus_rd;

    // Monitor: one clock after a read, compare with the oldest queued item.
    always @(negedge clk) begin
        #1;
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R11 unexpected read data actual=%h expected=none", bus_rdata);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] held;
        pin_in = 8'hA5;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state at the ports
        check("R1 rdata", bus_rdata, 8'h00);
        check("R1 pin_oe", pin_oe, 8'h00);
        check("R1 mcell", mcell_out, 8'h00);
        check("R1 slew", {4'h0, slew_sel}, 8'h00);
        @(negedge clk);
        rd(3'd1, 8'h00, "R1 dout");
        rd(3'd2, 8'h00, "R1 dir");
        rd(3'd3, 8'h00, "R1 drive");
        rd(3'd6, 8'h00, "R1 snap");
        rd(3'd5, 8'h00, "R8 mask reset");

        // R2: live pins, writes ignored
        rd(3'd0, 8'hA5, "R2 pins");
        wr(3'd0, 8'hFF);
        pin_in = 8'h3E;
        rd(3'd0, 8'h3E, "R2 pins after write");

        // R3: data out
        wr(3'd1, 8'h3C);
        #1 check("R3 pin_out", pin_out, 8'h3C);
        rd(3'd1, 8'h3C, "R3 readback");

        // R4 / R9: enables from direction OR logic term
        wr(3'd2, 8'h0F);
        #1 check("R4 dir only", pin_oe, 8'h0F);
        pld_oe = 8'hC0;
        #1 check("R4 dir or pld", pin_oe, 8'hCF);
        rd(3'd7, 8'hCF, "R9 oe view");
        wr(3'd7, 8'h00);
        rd(3'd7, 8'hCF, "R9 write ignored");

        // R6: drive register, open-drain on pins 7 and 5, slew 0110
        wr(3'd3, 8'hA6);
        rd(3'd3, 8'hA6, "R6 readback");
        #1 check("R6 slew", {4'h0, slew_sel}, 8'h06);

        // R5: dout 3C: pin5 holds 1 (released), pin7 holds 0 (still driven)
        wr(3'd2, 8'hFF);
        #1 check("R5 od release", pin_oe, 8'hDF);
        rd(3'd7, 8'hDF, "R5 oe view");
        wr(3'd1, 8'h1C);
        #1 check("R5 od drives zero", pin_oe, 8'hFF);

        // R7 / R8: masked macrocells
        wr(3'd4, 8'h55);
        #1 check("R7 unmasked load", mcell_out, 8'h55);
        wr(3'd5, 8'h0F);
        rd(3'd5, 8'h0F, "R8 mask readback");
        wr(3'd4, 8'hAA);
        #1 check("R7 masked load", mcell_out, 8'hA5);
        rd(3'd4, 8'hA5, "R7 readback");

        // R10: snapshot on strobe rising edge only
        pin_in = 8'h5A;
        rd(3'd6, 8'h00, "R10 no strobe");
        imc_strobe = 1'b1;
        @(negedge clk);
        pin_in = 8'h11;
        @(negedge clk);
        rd(3'd6, 8'h5A, "R10 captured, held while high");
        imc_strobe = 1'b0;
        wr(3'd6, 8'hFF);
        rd(3'd6, 8'h5A, "R10 write ignored");
        imc_strobe = 1'b1;
        @(negedge clk);
        imc_strobe = 1'b0;
        rd(3'd6, 8'h11, "R10 second edge");

        // R11: read data holds between reads
        @(negedge clk);
        #1 held = bus_rdata;
        repeat (3) @(negedge clk);
        #1 check("R11 hold", bus_rdata, held);

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_chk++; n_bad++;
            $display("FAIL R11 missing read data actual=%0d expected=0", exp_q.size());
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule